// File: doc/BRIEF.md
# Dual-Bank Event Frame Collector

The collector takes event words that arrive on one merged valid/data stream and stores them in one of two memory banks. Each word carries a tag naming the input stream it came from; up to twelve streams share the interface. A processor reads the other bank through a word-addressed port at the same time. The reader also sees the number of words in that bank, an overflow flag and a frame sequence number. Writing and reading never contend, so data-taking goes on with no dead time.

A system-wide swap strobe, issued once per one-second time frame, exchanges the roles of the two banks. A swap is held back while an event is partly written, so an event never spans two banks. At the swap, the count and overflow state of the frame just filled are latched for the reader. The write address of the fresh bank restarts at zero, and the frame sequence number advances.

Top module: `pingpong_collector`

## Requirements
- R1: After a synchronous reset, wr_bank is 0, rd_count is 0, rd_overflow is 0 and rd_frame_seq is 0.
- R2: Accepted words land in the write bank at consecutive addresses starting at 0. Each stored word is {in_src (bits 35:32), in_data (bits 31:0)}. rd_data shows the read bank's word at the rd_addr sampled on the previous clock edge.
- R3: Once the write bank holds DEPTH words, further words are discarded. After the next swap, rd_count equals DEPTH and rd_overflow is 1. The following frame starts with its overflow state cleared.
- R4: A swap strobe seen between events takes effect on that same clock edge. wr_bank toggles, and rd_count becomes the number of words stored in the finished frame, which may be zero.
- R5: A swap strobe seen during an event, after a word with in_last=0 and before the word with in_last=1, is deferred. It takes effect on the edge after the last word is accepted, and every word of that event stays in the old bank.
- R6: A word presented in the same cycle as a swap that takes effect is written to the new write bank at address 0. It is not counted in the finished frame.
- R7: rd_frame_seq increases by exactly one on each swap, wrapping modulo 2^SEQ_W, and is otherwise unchanged.
- R8: While the reader fetches the read bank, writes into the other bank do not alter any word the reader returns.
- R9: Several swap strobes that arrive while one swap is still deferred merge into a single swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word present on the merged event stream |
| in_last | input | 1 | Word is the final word of its event |
| in_src | input | SRC_W (4) | Input stream tag of the word |
| in_data | input | DATA_W (32) | Event payload word |
| swap_strobe | input | 1 | Frame-boundary request to exchange banks |
| rd_addr | input | AW (10) | Read address into the read bank |
| rd_data | output | SRC_W+DATA_W (36) | Word read from the read bank |
| rd_count | output | AW+1 (11) | Number of words in the read bank |
| rd_overflow | output | 1 | Words were dropped in the frame held by the read bank |
| rd_frame_seq | output | SEQ_W (8) | Sequence number of the frame in the read bank |
| wr_bank | output | 1 | Index of the bank now receiving data |

## Verification
The checks take for granted that events are well formed: a word with in_last=1 closes each event, so a deferred swap will be released. They also assume reset is held for at least one edge before any check counts. The stimulus opens and closes every event it starts, raises swap_strobe only for single cycles, and, when it tests deferral, holds the strobe inside an event whose last word follows within a few cycles. Read addresses stay below the latched count, so the reader never depends on stale words beyond the frame.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned PP_NUM_STREAMS = 12;
  localparam int unsigned PP_DATA_W      = 32;
  localparam int unsigned PP_SRC_W       = $clog2(PP_NUM_STREAMS);
  localparam int unsigned PP_DEPTH       = 1024;
  localparam int unsigned PP_SEQ_W       = 8;

  typedef enum logic {
    EV_IDLE = 1'b0,
    EV_OPEN = 1'b1
  } ev_state_t;
endpackage

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic swap_req,
  input  logic in_valid,
  input  logic in_last,
  output logic swap_now,
  output logic wr_sel,
  output logic mid_event
);
  import pp_pkg::*;

  ev_state_t ev_q;
  logic      pend_q;

  assign mid_event = (ev_q == EV_OPEN);
  assign swap_now  = (swap_req | pend_q) & ~mid_event;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= EV_IDLE;
      pend_q <= 1'b0;
      wr_sel <= 1'b0;
    end else begin
      if (in_valid) ev_q <= in_last ? EV_IDLE : EV_OPEN;
      if (swap_now)      pend_q <= 1'b0;
      else if (swap_req) pend_q <= 1'b1;
      if (swap_now) wr_sel <= ~wr_sel;
    end
  end
endmodule

// File: rtl/pp_write_path.sv
module pp_write_path #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_now,
  input  logic             in_valid,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [CNT_W-1:0] fill,
  output logic             ovf
);
  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W-1:0] eff_ptr;
  logic             room;
  logic             ovf_q;

  assign eff_ptr = swap_now ? '0 : ptr_q;
  assign room    = (eff_ptr < CNT_W'(DEPTH));
  assign wr_en   = in_valid & room;
  assign wr_addr = eff_ptr[AW-1:0];
  assign fill    = ptr_q;
  assign ovf     = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ptr_q <= eff_ptr + CNT_W'(wr_en);
      ovf_q <= (swap_now ? 1'b0 : ovf_q) | (in_valid & ~room);
    end
  end
endmodule

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_frame_regs.sv
module pp_frame_regs #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_now,
  input  logic [CNT_W-1:0] fill,
  input  logic             ovf,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_overflow,
  output logic [SEQ_W-1:0] rd_frame_seq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_count     <= '0;
      rd_overflow  <= 1'b0;
      rd_frame_seq <= '0;
    end else if (swap_now) begin
      rd_count     <= fill;
      rd_overflow  <= ovf;
      rd_frame_seq <= rd_frame_seq + 1'b1;
    end
  end
endmodule

// File: rtl/pingpong_collector.sv
module pingpong_collector #(
  parameter int unsigned DATA_W = pp_pkg::PP_DATA_W,
  parameter int unsigned SRC_W  = pp_pkg::PP_SRC_W,
  parameter int unsigned DEPTH  = pp_pkg::PP_DEPTH,
  parameter int unsigned SEQ_W  = pp_pkg::PP_SEQ_W,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CNT_W  = AW + 1,
  localparam int unsigned WORD_W = SRC_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [DATA_W-1:0] in_data,
  input  logic              swap_strobe,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_count,
  output logic              rd_overflow,
  output logic [SEQ_W-1:0]  rd_frame_seq,
  output logic              wr_bank
);
  logic             swap_now;
  logic             wr_sel;
  logic             mid_event;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [CNT_W-1:0] fill;
  logic             ovf;
  logic             tgt_sel;
  logic [WORD_W-1:0] wword;
  logic [WORD_W-1:0] bank_q [2];

  pp_swap_ctrl u_swap (
    .clk(clk), .rst(rst), .swap_req(swap_strobe),
    .in_valid(in_valid), .in_last(in_last),
    .swap_now(swap_now), .wr_sel(wr_sel), .mid_event(mid_event)
  );

  pp_write_path #(.DEPTH(DEPTH)) u_wpath (
    .clk(clk), .rst(rst), .swap_now(swap_now), .in_valid(in_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .fill(fill), .ovf(ovf)
  );

  assign tgt_sel = swap_now ? ~wr_sel : wr_sel;
  assign wword   = {in_src, in_data};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pp_bank_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_ram (
      .clk(clk),
      .we(wr_en && (tgt_sel == 1'(b))),
      .waddr(wr_addr),
      .wdata(wword),
      .raddr(rd_addr),
      .rdata(bank_q[b])
    );
  end

  assign rd_data = wr_sel ? bank_q[0] : bank_q[1];
  assign wr_bank = wr_sel;

  pp_frame_regs #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_frame (
    .clk(clk), .rst(rst), .swap_now(swap_now), .fill(fill), .ovf(ovf),
    .rd_count(rd_count), .rd_overflow(rd_overflow), .rd_frame_seq(rd_frame_seq)
  );
endmodule

// File: rtl/pp_collector_chk.sv
module pp_collector_chk #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CNT_W = 11,
  parameter int unsigned SEQ_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_bank,
  input logic [CNT_W-1:0] rd_count,
  input logic             rd_overflow,
  input logic [SEQ_W-1:0] rd_frame_seq,
  input logic             mid_event
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (wr_bank == 1'b0 && rd_count == '0 && !rd_overflow && rd_frame_seq == '0));

  p_count_cap_r3: assert property (@(posedge clk) disable iff (rst)
    rd_count <= CNT_W'(DEPTH));

  p_ovf_full_r3: assert property (@(posedge clk) disable iff (rst)
    rd_overflow |-> rd_count == CNT_W'(DEPTH));

  p_no_split_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_bank) |-> !$past(mid_event));

  p_seq_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_bank) |-> rd_frame_seq == SEQ_W'($past(rd_frame_seq) + 1'b1));

  p_seq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(wr_bank) |-> $stable(rd_frame_seq));
endmodule

bind pingpong_collector pp_collector_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_bank(wr_bank), .rd_count(rd_count),
  .rd_overflow(rd_overflow), .rd_frame_seq(rd_frame_seq), .mid_event(mid_event)
);

// File: tb/pingpong_collector_test.sv
module pingpong_collector_test;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [3:0]  in_src = '0;
  logic [31:0] in_data = '0;
  logic        swap_strobe = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic [35:0] rd_data;
  logic [10:0] rd_count;
  logic        rd_overflow;
  logic [7:0]  rd_frame_seq;
  logic        wr_bank;

  int total = 0;
  int bad = 0;

  logic [35:0] exp_wr[$];
  logic [35:0] exp_rd[$];
  bit          m_ovf = 0;
  bit          exp_ovf = 0;
  logic [7:0]  exp_seq = '0;
  logic        exp_bank = 1'b0;

  // columns: events, words per event, source tag, expected word count
  localparam int unsigned TBL[4][4] = '{
    '{2, 3, 1, 6},
    '{1, 1, 11, 1},
    '{4, 5, 7, 20},
    '{0, 0, 3, 0}
  };

  always #5 clk = ~clk;

  pingpong_collector uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_src(in_src), .in_data(in_data), .swap_strobe(swap_strobe),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_count(rd_count),
    .rd_overflow(rd_overflow), .rd_frame_seq(rd_frame_seq), .wr_bank(wr_bank)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_push(input logic [3:0] s, input logic [31:0] d);
    if (exp_wr.size() < DEPTH) exp_wr.push_back({s, d});
    else m_ovf = 1;
  endtask

  task automatic model_swap();
    exp_rd = exp_wr;
    exp_wr.delete();
    exp_ovf = m_ovf;
    m_ovf = 0;
    exp_seq = exp_seq + 8'd1;
    exp_bank = ~exp_bank;
  endtask

  task automatic send(input logic [3:0] s, input logic [31:0] d,
                      input logic l, input logic sw);
    @(negedge clk);
    in_valid = 1'b1; in_src = s; in_data = d; in_last = l; swap_strobe = sw;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; swap_strobe = 1'b0;
  endtask

  task automatic do_swap();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; swap_strobe = 1'b1;
    @(negedge clk);
    swap_strobe = 1'b0;
    model_swap();
  endtask

  task automatic check_status(input string req);
    chk(rd_count == 11'(exp_rd.size()), req, "rd_count", rd_count, exp_rd.size());
    chk(rd_overflow == exp_ovf, req, "rd_overflow", rd_overflow, exp_ovf);
    chk(rd_frame_seq == exp_seq, req, "rd_frame_seq", rd_frame_seq, exp_seq);
    chk(wr_bank == exp_bank, req, "wr_bank", wr_bank, exp_bank);
  endtask

  task automatic read_back(input string req);
    bit all_ok = 1;
    for (int i = 0; i < exp_rd.size(); i++) begin
      rd_addr = 10'(i);
      @(negedge clk);
      if (rd_data !== exp_rd[i]) begin
        all_ok = 0;
        chk(0, req, $sformatf("rd_data[%0d]", i), rd_data, exp_rd[i]);
      end
    end
    chk(all_ok, req, "frame contents", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(wr_bank == 1'b0, "R1", "wr_bank", wr_bank, 0);
    chk(rd_count == '0, "R1", "rd_count", rd_count, 0);
    chk(rd_overflow == 1'b0, "R1", "rd_overflow", rd_overflow, 0);
    chk(rd_frame_seq == '0, "R1", "rd_frame_seq", rd_frame_seq, 0);

    // R2 R4 R7: table of frames
    for (int f = 0; f < 4; f++) begin
      for (int e = 0; e < int'(TBL[f][0]); e++)
        for (int w = 0; w < int'(TBL[f][1]); w++) begin
          logic [31:0] d;
          d = {8'(f), 8'(e), 16'(w)};
          send(4'(TBL[f][2]), d, (w == int'(TBL[f][1]) - 1), 1'b0);
          model_push(4'(TBL[f][2]), d);
        end
      do_swap();
      chk(rd_count == 11'(TBL[f][3]), "R4", "table count", rd_count, TBL[f][3]);
      check_status("R7");
      read_back("R2");
    end

    // R8: read old frame while the other bank is written
    for (int w = 0; w < 5; w++) begin
      send(4'd2, 32'hA000 + 32'(w), 1'b1, 1'b0);
      model_push(4'd2, 32'hA000 + 32'(w));
    end
    do_swap();
    check_status("R8");
    fork
      read_back("R8");
      begin
        for (int w = 0; w < 20; w++) begin
          send(4'd9, 32'hB000 + 32'(w), 1'b1, 1'b0);
          model_push(4'd9, 32'hB000 + 32'(w));
        end
        idle();
      end
    join
    do_swap();
    check_status("R8");
    read_back("R8");

    // R5 R9: strobes inside an event are deferred and merged
    send(4'd5, 32'hC0, 1'b0, 1'b0); model_push(4'd5, 32'hC0);
    send(4'd5, 32'hC1, 1'b0, 1'b1); model_push(4'd5, 32'hC1);
    send(4'd5, 32'hC2, 1'b0, 1'b1); model_push(4'd5, 32'hC2);
    send(4'd5, 32'hC3, 1'b1, 1'b0); model_push(4'd5, 32'hC3);
    chk(wr_bank == exp_bank, "R5", "bank held during event", wr_bank, exp_bank);
    idle();
    chk(wr_bank == exp_bank, "R5", "bank held on last word", wr_bank, exp_bank);
    idle();
    model_swap();
    check_status("R9");
    read_back("R5");
    repeat (3) idle();
    chk(rd_frame_seq == exp_seq, "R9", "single increment", rd_frame_seq, exp_seq);

    // R6: word in the swap cycle goes to the new bank at address 0
    send(4'd8, 32'hD0, 1'b1, 1'b0); model_push(4'd8, 32'hD0);
    send(4'd8, 32'hD1, 1'b1, 1'b1); model_swap(); model_push(4'd8, 32'hD1);
    idle();
    check_status("R6");
    read_back("R6");
    do_swap();
    check_status("R6");
    read_back("R6");

    // R3: overflow
    for (int w = 0; w < DEPTH + 6; w++) begin
      send(4'(w % 12), 32'(w), 1'b1, 1'b0);
      model_push(4'(w % 12), 32'(w));
    end
    do_swap();
    chk(rd_count == 11'(DEPTH), "R3", "full count", rd_count, DEPTH);
    chk(rd_overflow == 1'b1, "R3", "overflow flag", rd_overflow, 1);
    check_status("R3");
    read_back("R3");
    send(4'd1, 32'hE0, 1'b1, 1'b0); model_push(4'd1, 32'hE0);
    do_swap();
    chk(rd_overflow == 1'b0, "R3", "overflow cleared", rd_overflow, 0);
    check_status("R3");
    read_back("R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule